// File: doc/BRIEF.md
# Lazy Instruction Predictor Table

This block keeps a small fully associative set of instruction addresses that are expected to sit in the issue queue for a long time before they issue. The front end presents each fetch address on the lookup port. One cycle later the block returns a registered lazy-prediction bit, which travels with the instruction to the issue queue.

When an instruction issues, the back end reports its address and the number of cycles it waited in the queue on the update port. If the wait reached the lazy threshold, the address is recorded. A PC that is already recorded is not copied again; it is marked as recently useful instead. A shorter wait erases the address if it is present.

When the table is full, a new address displaces an entry chosen by a second-chance sweep. The sweep starts at a rotating pointer. Each entry has a single used flag, and an entry whose flag is set is spared once before it can be chosen.

Top module: `lzp_table`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every entry, clears every used flag and moves the replacement pointer to entry 0. After reset every lookup reports not lazy.
- R2: A lookup presented with `lk_valid` high at edge t gives `pred_valid` high after edge t. The same edge sets `pred_lazy` high exactly when a valid entry holds `lk_pc`. `pred_valid` is low after an edge with no lookup, and `pred_lazy` is never high while `pred_valid` is low.
- R3: An update whose `up_delay` is at least `LAZY_THRESH` (default 10) records `up_pc`. A delay of 9 records nothing.
- R4: An update whose delay is below `LAZY_THRESH` invalidates the entry holding `up_pc`. If no entry holds that PC, the update leaves the table unchanged.
- R5: Recording a PC that is already present leaves the entry count unchanged and creates no second copy. It sets that entry's used flag. A single later short-delay update then removes the PC completely.
- R6: While any entry is invalid, a newly recorded PC goes into the lowest-numbered invalid entry. No valid PC is displaced.
- R7: When the table is full, the sweep examines entries upward from the pointer, wrapping at the top. It clears the used flag of each entry it passes and replaces the first entry whose used flag is clear. The pointer then moves to the entry after the victim. Newly written entries start with the used flag clear.
- R8: When the table is full and every used flag is set, the entry at the pointer is replaced, all used flags are cleared, and the pointer advances by one.
- R9: A lookup and an update in the same cycle are both accepted. The lookup reports the table state from before that update.
- R10: Matching compares all `PC_W` address bits. PCs that differ only in bit 31 or only in bit 0 do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch address to look up |
| pred_valid | output | 1 | Registered: a lookup result is present |
| pred_lazy | output | 1 | Registered: the looked-up PC is predicted lazy |
| up_valid | input | 1 | Update request this cycle |
| up_pc | input | PC_W | Address of the issued instruction |
| up_delay | input | DELAY_W | Issue-queue wait of that instruction in cycles |

## Verification
The threshold is tried at 9, 10 and 255 cycles. This tells an off-by-one comparison apart from a correct one. Replacement is tried from three starting states of a full table: a few refreshed entries, every entry refreshed, and one entry freed by a removal. Each state separates a different part of the victim choice: spared flags, the all-used fallback, and the preference for free entries. Further patterns cover:
- a duplicate insertion followed by a single removal;
- a removal of a PC that is not in the table;
- a lookup and an insertion of the same PC in the same cycle;
- addresses one bit apart.

Together these show duplicates, false removals, ordering errors and partial tag compares.

// File: rtl/lzp_pkg.sv
package lzp_pkg;

  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_INSERT = 2'd1,
    UPD_REMOVE = 2'd2
  } upd_kind_e;

endpackage

// File: rtl/lzp_match.sv
// Parallel compare of one key against every stored address.
module lzp_match #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32
) (
  input  logic [ENTRIES-1:0][PC_W-1:0] tbl_pc,
  input  logic [ENTRIES-1:0]           tbl_valid,
  input  logic [PC_W-1:0]              key,
  output logic [ENTRIES-1:0]           hit_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = tbl_valid[g] && (tbl_pc[g] == key);
  end

endmodule

// File: rtl/lzp_onehot_enc.sv
// One-hot (or zero) vector to binary index.
module lzp_onehot_enc #(
  parameter int N     = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/lzp_victim.sv
// Second-chance sweep over a full table, starting at the pointer.
module lzp_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] used,
  input  logic [IDX_W-1:0]   hand,
  output logic [IDX_W-1:0]   victim,
  output logic [ENTRIES-1:0] clear_mask,
  output logic [IDX_W-1:0]   next_hand
);

  logic found;

  always_comb begin
    found      = 1'b0;
    victim     = hand;
    clear_mask = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int s;
      s = int'(hand) + k;
      if (s >= ENTRIES) s = s - ENTRIES;
      if (!found) begin
        if (!used[s]) begin
          found  = 1'b1;
          victim = IDX_W'(s);
        end else begin
          clear_mask[s] = 1'b1;
        end
      end
    end
    // With every flag set the sweep wraps back to the pointer.
    if (!found) victim = hand;
  end

  always_comb begin
    int n;
    n = int'(victim) + 1;
    if (n >= ENTRIES) n = 0;
    next_hand = IDX_W'(n);
  end

endmodule

// File: rtl/lzp_table.sv
module lzp_table
  import lzp_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter int PC_W        = 32,
  parameter int DELAY_W     = 8,
  parameter int LAZY_THRESH = 10,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               pred_valid,
  output logic               pred_lazy,
  input  logic               up_valid,
  input  logic [PC_W-1:0]    up_pc,
  input  logic [DELAY_W-1:0] up_delay
);

  localparam logic [DELAY_W-1:0] THRESH_V = DELAY_W'(LAZY_THRESH);

  logic [ENTRIES-1:0][PC_W-1:0] pc_q;
  logic [ENTRIES-1:0]           valid_q;
  logic [ENTRIES-1:0]           used_q;
  logic [IDX_W-1:0]             hand_q;

  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] up_hit_vec;
  logic               up_hit;
  upd_kind_e          kind;

  logic [ENTRIES-1:0] free_oh;
  logic               any_free;
  logic [IDX_W-1:0]   free_idx;

  logic [IDX_W-1:0]   vic_idx;
  logic [ENTRIES-1:0] vic_clear;
  logic [IDX_W-1:0]   vic_next_hand;

  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;

  // Lookup and update each see the table state from before this edge.
  lzp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lk_match (
    .tbl_pc   (pc_q),
    .tbl_valid(valid_q),
    .key      (lk_pc),
    .hit_vec  (lk_hit_vec)
  );

  lzp_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_up_match (
    .tbl_pc   (pc_q),
    .tbl_valid(valid_q),
    .key      (up_pc),
    .hit_vec  (up_hit_vec)
  );

  assign up_hit = |up_hit_vec;

  always_comb begin
    if (!up_valid)                kind = UPD_NONE;
    else if (up_delay >= THRESH_V) kind = UPD_INSERT;
    else                          kind = UPD_REMOVE;
  end

  // Lowest-numbered invalid entry, as a one-hot vector.
  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  assign any_free = ~&valid_q;

  lzp_onehot_enc #(.N(ENTRIES)) u_free_enc (
    .onehot(free_oh),
    .idx   (free_idx)
  );

  lzp_victim #(.ENTRIES(ENTRIES)) u_victim (
    .used      (used_q),
    .hand      (hand_q),
    .victim    (vic_idx),
    .clear_mask(vic_clear),
    .next_hand (vic_next_hand)
  );

  assign wr_en  = (kind == UPD_INSERT) && !up_hit;
  assign wr_idx = any_free ? free_idx : vic_idx;

  // Address storage: one write port, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) pc_q[wr_idx] <= up_pc;
  end

  // Entry state and replacement pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      used_q  <= '0;
      hand_q  <= '0;
    end else begin
      case (kind)
        UPD_INSERT: begin
          if (up_hit) begin
            used_q <= used_q | up_hit_vec;
          end else if (any_free) begin
            valid_q[free_idx] <= 1'b1;
            used_q[free_idx]  <= 1'b0;
          end else begin
            used_q          <= used_q & ~vic_clear;
            used_q[vic_idx] <= 1'b0;
            hand_q          <= vic_next_hand;
          end
        end
        UPD_REMOVE: begin
          valid_q <= valid_q & ~up_hit_vec;
          used_q  <= used_q & ~up_hit_vec;
        end
        default: ;
      endcase
    end
  end

  // Registered prediction.
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_lazy  <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      pred_lazy  <= lk_valid && (|lk_hit_vec);
    end
  end

endmodule

// File: rtl/lzp_checker.sv
module lzp_checker #(
  parameter int ENTRIES     = 64,
  parameter int PC_W        = 32,
  parameter int DELAY_W     = 8,
  parameter int LAZY_THRESH = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [PC_W-1:0]    lk_pc,
  input logic               pred_valid,
  input logic               pred_lazy,
  input logic               up_valid,
  input logic [PC_W-1:0]    up_pc,
  input logic [DELAY_W-1:0] up_delay,
  input logic [ENTRIES-1:0] valid_q,
  input logic               up_hit
);

  localparam logic [DELAY_W-1:0] TH = DELAY_W'(LAZY_THRESH);

  a_r2_pred_tracks_lookup: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pred_valid == $past(lk_valid)));

  a_r2_lazy_needs_valid: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> !pred_lazy);

  a_r3_insert_visible: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay >= TH) ##1 (lk_valid && lk_pc == $past(up_pc))
    |=> pred_lazy);

  a_r4_remove_visible: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay < TH) ##1 (lk_valid && lk_pc == $past(up_pc))
    |=> !pred_lazy);

  a_r4_absent_remove_noop: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay < TH && !up_hit) |=> $stable(valid_q));

  a_r5_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay >= TH && up_hit) |=> $stable(valid_q));

  a_r6_fill_grows: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay >= TH && !up_hit && !(&valid_q))
    |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

  a_r7_full_stays_full: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_delay >= TH && (&valid_q)) |=> (&valid_q));

endmodule

bind lzp_table lzp_checker #(
  .ENTRIES    (ENTRIES),
  .PC_W       (PC_W),
  .DELAY_W    (DELAY_W),
  .LAZY_THRESH(LAZY_THRESH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_pc     (lk_pc),
  .pred_valid(pred_valid),
  .pred_lazy (pred_lazy),
  .up_valid  (up_valid),
  .up_pc     (up_pc),
  .up_delay  (up_delay),
  .valid_q   (valid_q),
  .up_hit    (up_hit)
);

// File: tb/lzp_table_tb.sv
module lzp_table_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        pred_valid;
  logic        pred_lazy;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [7:0]  up_delay = '0;

  always #5 clk = ~clk;

  lzp_table u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_lazy(pred_lazy),
    .up_valid(up_valid), .up_pc(up_pc), .up_delay(up_delay)
  );

  typedef struct {
    logic [31:0] pc;
    logic        exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  function automatic logic [31:0] pcn(input int i);
    return 32'h0040_0000 + 32'(i) * 32'd4;
  endfunction

  task automatic drive(input logic lv, input logic [31:0] lpc, input logic exp,
                       input string tag, input logic uv, input logic [31:0] upc,
                       input logic [7:0] ud);
    @(negedge clk);
    lk_valid = lv;
    lk_pc    = lpc;
    up_valid = uv;
    up_pc    = upc;
    up_delay = ud;
    if (lv) sb.push_back('{pc: lpc, exp: exp, tag: tag});
  endtask

  task automatic look(input logic [31:0] pc, input logic exp, input string tag);
    drive(1'b1, pc, exp, tag, 1'b0, '0, '0);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [7:0] d);
    drive(1'b0, '0, 1'b0, "", 1'b1, pc, d);
  endtask

  task automatic idle_drain();
    drive(1'b0, '0, 1'b0, "", 1'b0, '0, '0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    idle_drain();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill_all();
    for (int i = 0; i < 64; i++) upd(pcn(i), 8'd12);
  endtask

  // Monitor: compare each registered result with the queued expectation.
  always @(negedge clk) begin
    if (!rst && pred_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: pred_valid=1 with no lookup issued, actual 1 expected 0");
      end else begin
        item_t it;
        it = sb.pop_front();
        if (pred_lazy !== it.exp) begin
          fails++;
          $display("FAIL %s: pc=%h pred_lazy actual %b expected %b",
                   it.tag, it.pc, pred_lazy, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pred_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: pred_valid after reset actual %b expected 0", pred_valid);
    end

    // R1: empty after reset
    look(pcn(0), 1'b0, "R1");
    look(32'hFFFF_FFFC, 1'b0, "R1");

    // R3: threshold boundary
    upd(pcn(1), 8'd9);
    look(pcn(1), 1'b0, "R3");
    upd(pcn(2), 8'd10);
    look(pcn(2), 1'b1, "R3");
    upd(pcn(3), 8'd255);
    look(pcn(3), 1'b1, "R3");

    // R4: removal, then removal of an absent PC
    upd(pcn(2), 8'd3);
    look(pcn(2), 1'b0, "R4");
    upd(pcn(77), 8'd0);
    look(pcn(3), 1'b1, "R4");

    // R5: duplicate insert, single removal clears it
    upd(pcn(5), 8'd20);
    upd(pcn(5), 8'd20);
    upd(pcn(5), 8'd1);
    look(pcn(5), 1'b0, "R5");

    // R9: same-cycle lookup and insert of one PC
    drive(1'b1, pcn(9), 1'b0, "R9", 1'b1, pcn(9), 8'd40);
    look(pcn(9), 1'b1, "R9");
    // R9: same-cycle lookup and removal
    drive(1'b1, pcn(9), 1'b1, "R9", 1'b1, pcn(9), 8'd2);
    look(pcn(9), 1'b0, "R9");

    // R10: full-width compare
    upd(32'h0000_1234, 8'd11);
    look(32'h8000_1234, 1'b0, "R10");
    look(32'h0000_1235, 1'b0, "R10");
    look(32'h0000_1234, 1'b1, "R10");

    // R7: spared entries then victim
    do_reset();
    fill_all();
    upd(pcn(0), 8'd15);
    upd(pcn(1), 8'd15);
    upd(pcn(64), 8'd10);
    look(pcn(2), 1'b0, "R7");
    look(pcn(0), 1'b1, "R7");
    look(pcn(1), 1'b1, "R7");
    look(pcn(64), 1'b1, "R7");
    upd(pcn(65), 8'd10);
    look(pcn(3), 1'b0, "R7");
    look(pcn(65), 1'b1, "R7");
    look(pcn(4), 1'b1, "R7");

    // R8: every used flag set
    do_reset();
    fill_all();
    for (int i = 0; i < 64; i++) upd(pcn(i), 8'd30);
    upd(pcn(100), 8'd10);
    look(pcn(0), 1'b0, "R8");
    look(pcn(100), 1'b1, "R8");
    look(pcn(63), 1'b1, "R8");
    upd(pcn(101), 8'd10);
    look(pcn(1), 1'b0, "R8");
    look(pcn(2), 1'b1, "R8");

    // R6: free slot preferred over eviction
    do_reset();
    fill_all();
    upd(pcn(10), 8'd2);
    upd(pcn(200), 8'd30);
    look(pcn(0), 1'b1, "R6");
    look(pcn(10), 1'b0, "R6");
    look(pcn(200), 1'b1, "R6");
    look(pcn(1), 1'b1, "R6");

    // R4: absent removal on a full table
    upd(pcn(300), 8'd0);
    look(pcn(5), 1'b1, "R4");

    // R1: reset wipes a full table
    do_reset();
    look(pcn(200), 1'b0, "R1");
    look(pcn(7), 1'b0, "R1");

    idle_drain();
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: results missing, actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule